// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit binary down-counters that advance on a shared one-cycle count-enable strobe. The strobe typically runs at a nominal rate near 1.19 MHz. A host reaches the block through a byte-wide port with a 2-bit address. Addresses 0 to 2 are the data ports of the three channels, and address 3 takes a command byte. Each channel drives one output pin, and its waveform depends on the mode the channel was given.

A command byte either configures a channel or freezes a snapshot of that channel's count for reading. Counts are always moved as two bytes, low byte first. Command bytes that ask for something the block does not implement are refused. A refused command produces a one-cycle error pulse and changes nothing.

Top module: `pit_timer3`

## Requirements
- R1: A synchronous active-low reset clears every count, period, snapshot and byte pointer, drives all three outputs low and holds `cmd_err` low.
- R2: The command byte at address 3 is decoded as follows. Bits [7:6] select the channel, and 3 is a read-back request, which is refused. Bits [5:4] give the access: 0 is a snapshot, 3 is low-then-high byte, and 1 or 2 is refused. Bits [3:1] give the mode: 0, 2 and 3 are accepted and any other value is refused. Bit 0 set, meaning decimal counting, is refused. A refused byte raises `cmd_err` for exactly the following cycle and leaves every channel untouched, byte pointers included.
- R3: The first data byte written to a channel replaces the low count byte, halts the channel and drives its output low. The second byte replaces the high byte, copies the 16-bit value into the reload period and starts counting if the value is nonzero. A zero value leaves the channel idle with its output low.
- R4: Reads of a channel's data port alternate between the low byte and the high byte of the live count. A read at address 3 returns 0x00 and has no effect.
- R5: A snapshot command copies the count into a holding register, and subsequent reads are served from that register. A further snapshot command is ignored until the held value has been read. The hold is released after its high byte has been read.
- R6: In mode 0, the output rises after N count enables and stays high until the next low-byte write.
- R7: In mode 2, the output is high. It drops for one enable interval when the count reaches 1, and it returns high as the count reloads N. The cycle repeats every N enables.
- R8: In mode 3, the output is a square wave that repeats every N enables. It is high for ceil(N/2) enables and low for floor(N/2) enables.
- R9: Counts change only on cycles with `cnt_en` high, and each channel counts independently of the others.
- R10: An accepted configuration byte sets the channel's mode and returns both its byte pointers to the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | One-cycle count-enable strobe |
| addr | input | 2 | 0-2 channel data port, 3 command byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, advances the read pointer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port, combinational |
| timer_out | output | 3 | Channel outputs, bit i for channel i |
| cmd_err | output | 1 | One-cycle pulse after a refused command byte |

## Verification
A byte pointer in the wrong state swaps the two halves of every later word. This shows up on the very next two-byte read, or as a count loaded with its halves exchanged. The bench uses this to show that refused commands leave the pointers alone and that accepted ones reset them. A stuck snapshot makes repeated reads stay frozen while counting continues, and that appears on the first read after the snapshot should have been released. Errors in the reload or toggle logic move the edges of `timer_out` by one or more enables within the first period, so the bench samples the output after every enable.

// File: rtl/pit_pkg.sv
// Package: shared encodings of the interval timer.
// Assumes an 8-bit command byte whose field positions are fixed by the host.
package pit_pkg;
    localparam int SEL_W = 2;
    localparam logic [1:0] SEL_READBACK = 2'd3;
    localparam logic [1:0] ACC_SNAPSHOT = 2'd0;
    localparam logic [1:0] ACC_LOHI     = 2'd3;

    typedef enum logic [2:0] {
        PIT_M_TERMINAL = 3'd0,
        PIT_M_RATE     = 3'd2,
        PIT_M_SQUARE   = 3'd3
    } pit_mode_e;
endpackage

// File: rtl/pit_cmd_decode.sv
// Module: splits a command byte into per-channel snapshot and configure
// strobes and flags bytes that request unsupported features.
// Assumes ctl_wr is high for one cycle per host write to the command address.
module pit_cmd_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_word,
    output logic [NUM_CH-1:0] snap_stb,
    output logic [NUM_CH-1:0] cfg_stb,
    output pit_mode_e         cfg_mode,
    output logic              bad_cmd
);
    logic [SEL_W-1:0] sel;
    logic [1:0]       acc;
    logic [2:0]       mode_raw;
    logic             bcd;
    logic             mode_ok;

    // Purpose: field extraction and legality check.
    always_comb begin
        sel      = ctl_word[7:6];
        acc      = ctl_word[5:4];
        mode_raw = ctl_word[3:1];
        bcd      = ctl_word[0];
        mode_ok  = (mode_raw == 3'd0) || (mode_raw == 3'd2) || (mode_raw == 3'd3);
        cfg_mode = pit_mode_e'(mode_raw);
        bad_cmd  = ctl_wr && ((sel == SEL_READBACK) || (int'(sel) >= NUM_CH) ||
                   ((acc != ACC_SNAPSHOT) && ((acc != ACC_LOHI) || bcd || !mode_ok)));
    end

    // Purpose: one strobe per channel for accepted commands.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            snap_stb[i] = ctl_wr && !bad_cmd && (int'(sel) == i) && (acc == ACC_SNAPSHOT);
            cfg_stb[i]  = ctl_wr && !bad_cmd && (int'(sel) == i) && (acc == ACC_LOHI);
        end
    end
endmodule

// File: rtl/pit_channel.sv
// Module: one down-counter channel with two-byte load, shared read pointer,
// count snapshot and three output waveforms.
// Assumes strobes are single-cycle and mutually exclusive per channel.
module pit_channel
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              snap_stb,
    input  logic              cfg_stb,
    input  pit_mode_e         cfg_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic              out_o
);
    localparam int CNT_W = 2 * DATA_W;

    pit_mode_e         mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  snap_q;
    logic              snap_on_q;
    logic              rd_hi_q;
    logic              wr_hi_q;
    logic              run_q;
    logic              out_q;
    logic [CNT_W-1:0]  rd_src;
    logic [CNT_W-1:0]  new_val;

    assign new_val = {wdata, cnt_q[DATA_W-1:0]};

    // Purpose: mode register and write-byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= PIT_M_TERMINAL;
            wr_hi_q <= 1'b0;
        end else if (cfg_stb) begin
            mode_q  <= cfg_mode;
            wr_hi_q <= 1'b0;
        end else if (wr_stb) begin
            wr_hi_q <= ~wr_hi_q;
        end
    end

    // Purpose: snapshot holding register and read-byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q    <= '0;
            snap_on_q <= 1'b0;
            rd_hi_q   <= 1'b0;
        end else if (cfg_stb) begin
            rd_hi_q <= 1'b0;
        end else if (snap_stb) begin
            if (!snap_on_q) begin
                snap_q    <= cnt_q;
                snap_on_q <= 1'b1;
                rd_hi_q   <= 1'b0;
            end
        end else if (rd_stb) begin
            rd_hi_q <= ~rd_hi_q;
            if (rd_hi_q) begin
                snap_on_q <= 1'b0;
            end
        end
    end

    // Purpose: count, period, run flag and output waveform.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= '0;
            run_q    <= 1'b0;
            out_q    <= 1'b0;
        end else if (wr_stb && !wr_hi_q) begin
            cnt_q[DATA_W-1:0] <= wdata;
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else if (wr_stb) begin
            cnt_q    <= new_val;
            period_q <= new_val;
            run_q    <= (new_val != '0);
            out_q    <= (new_val != '0) && (mode_q != PIT_M_TERMINAL);
        end else if (tick && run_q) begin
            unique case (mode_q)
                PIT_M_RATE: begin
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q <= period_q;
                        out_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(2)) begin
                            out_q <= 1'b0;
                        end
                    end
                end
                PIT_M_SQUARE: begin
                    if (cnt_q <= CNT_W'(2)) begin
                        out_q <= ~out_q;
                        cnt_q <= out_q ? {period_q[CNT_W-1:1], 1'b0} : period_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(2);
                    end
                end
                default: begin
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q <= '0;
                        out_q <= 1'b1;
                        run_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Purpose: select snapshot or live count and the current byte.
    always_comb begin
        rd_src  = snap_on_q ? snap_q : cnt_q;
        rd_byte = rd_hi_q ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
    end

    assign out_o = out_q;
endmodule

// File: rtl/pit_timer3.sv
// Module: top of the three-channel interval timer; decodes host accesses,
// instantiates the channels and muxes read data.
// Assumes addr, wr_en and rd_en are synchronous to clk.
module pit_timer3
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] timer_out,
    output logic              cmd_err
);
    localparam logic [1:0] CMD_ADDR = 2'd3;

    logic [NUM_CH-1:0] snap_stb;
    logic [NUM_CH-1:0] cfg_stb;
    pit_mode_e         cfg_mode;
    logic              bad_cmd;
    logic              err_q;
    logic [DATA_W-1:0] ch_rd [NUM_CH];

    pit_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .ctl_wr   (wr_en && (addr == CMD_ADDR)),
        .ctl_word (wdata[7:0]),
        .snap_stb (snap_stb),
        .cfg_stb  (cfg_stb),
        .cfg_mode (cfg_mode),
        .bad_cmd  (bad_cmd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pit_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (cnt_en),
            .wr_stb   (wr_en && (int'(addr) == g)),
            .rd_stb   (rd_en && (int'(addr) == g)),
            .snap_stb (snap_stb[g]),
            .cfg_stb  (cfg_stb[g]),
            .cfg_mode (cfg_mode),
            .wdata    (wdata),
            .rd_byte  (ch_rd[g]),
            .out_o    (timer_out[g])
        );
    end

    // Purpose: one-cycle error pulse after a refused command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad_cmd;
        end
    end

    // Purpose: read data mux, zero for the command address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(addr) == i) begin
                rdata = ch_rd[i];
            end
        end
    end

    assign cmd_err = err_q;
endmodule

// File: rtl/pit_timer3_chk.sv
// Module: port-level properties of the interval timer, bound to the top.
// Assumes the default three-channel, byte-wide configuration.
module pit_timer3_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [2:0] timer_out,
    input logic       cmd_err
);
    assert_err_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(wr_en && (addr == 2'd3)));

    assert_readback_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd3) && (wdata[7:6] == 2'd3)) |=> cmd_err);

    assert_refused_keeps_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd3) && (wdata[7:6] == 2'd3) && !cnt_en) |=> $stable(timer_out));

    assert_snapshot_keeps_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd3) && (wdata[5:4] == 2'd0) && !cnt_en) |=> $stable(timer_out));

    assert_idle_holds_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en) |=> $stable(timer_out));

    assert_cmd_addr_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 2'd3)) |-> (rdata == 8'h00));
endmodule

bind pit_timer3 pit_timer3_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .timer_out (timer_out),
    .cmd_err   (cmd_err)
);

// File: tb/tb_pit_timer3.sv
`timescale 1ns/1ps
module tb_pit_timer3;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] timer_out;
    logic       cmd_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pit_timer3 dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .timer_out(timer_out), .cmd_err(cmd_err)
    );

    always #2 clk = ~clk;

    // Vector: {op[2:0], addr[1:0], data[7:0], exp[7:0], req[3:0]}
    // op 0 write, 1 read and compare, 2 one enable, 3 compare timer_out, 4 compare cmd_err
    localparam int NV = 52;
    localparam logic [24:0] VEC [NV] = '{
        {3'd0, 2'd3, 8'h30, 8'h00, 4'd10}, // R10 ch0 mode 0 two-byte
        {3'd4, 2'd0, 8'h00, 8'h00, 4'd2},  // R2 accepted, no error
        {3'd0, 2'd0, 8'h03, 8'h00, 4'd3},
        {3'd3, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 low byte drives out low
        {3'd0, 2'd0, 8'h00, 8'h00, 4'd3},
        {3'd1, 2'd0, 8'h00, 8'h03, 4'd4},  // R4 low byte first
        {3'd1, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 high byte
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd6},
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd6},
        {3'd3, 2'd0, 8'h00, 8'h00, 4'd6},  // R6 low before N enables
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd6},
        {3'd3, 2'd0, 8'h00, 8'h01, 4'd6},  // R6 high after N
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd6},
        {3'd3, 2'd0, 8'h00, 8'h01, 4'd6},  // R6 stays high
        {3'd1, 2'd0, 8'h00, 8'h00, 4'd6},
        {3'd1, 2'd0, 8'h00, 8'h00, 4'd6},
        {3'd0, 2'd0, 8'h05, 8'h00, 4'd3},
        {3'd3, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 low byte write clears out
        {3'd0, 2'd0, 8'h00, 8'h00, 4'd3},
        {3'd0, 2'd3, 8'h74, 8'h00, 4'd7},  // R7 ch1 mode 2
        {3'd0, 2'd1, 8'h03, 8'h00, 4'd7},
        {3'd0, 2'd1, 8'h00, 8'h00, 4'd7},
        {3'd3, 2'd0, 8'h00, 8'h02, 4'd7},
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd7},
        {3'd3, 2'd0, 8'h00, 8'h02, 4'd7},
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd7},
        {3'd3, 2'd0, 8'h00, 8'h00, 4'd7},  // R7 low pulse at count 1
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd7},
        {3'd3, 2'd0, 8'h00, 8'h02, 4'd7},  // R7 high after reload
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd9},
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd9},
        {3'd3, 2'd0, 8'h00, 8'h01, 4'd9},  // R9 channels independent
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd7},
        {3'd3, 2'd0, 8'h00, 8'h03, 4'd7},
        {3'd0, 2'd3, 8'h40, 8'h00, 4'd5},  // R5 snapshot ch1 at 3
        {3'd4, 2'd0, 8'h00, 8'h00, 4'd5},
        {3'd2, 2'd0, 8'h00, 8'h00, 4'd5},
        {3'd0, 2'd3, 8'h40, 8'h00, 4'd5},  // R5 second snapshot ignored
        {3'd1, 2'd1, 8'h00, 8'h03, 4'd5},
        {3'd1, 2'd1, 8'h00, 8'h00, 4'd5},
        {3'd1, 2'd1, 8'h00, 8'h02, 4'd5},  // R5 released, live count
        {3'd1, 2'd1, 8'h00, 8'h00, 4'd4},
        {3'd0, 2'd3, 8'hC0, 8'h00, 4'd2},  // R2 read-back refused
        {3'd4, 2'd0, 8'h00, 8'h01, 4'd2},
        {3'd0, 2'd3, 8'h32, 8'h00, 4'd2},  // R2 mode 1 refused
        {3'd4, 2'd0, 8'h00, 8'h01, 4'd2},
        {3'd0, 2'd3, 8'h10, 8'h00, 4'd2},  // R2 single-byte access refused
        {3'd4, 2'd0, 8'h00, 8'h01, 4'd2},
        {3'd0, 2'd3, 8'h31, 8'h00, 4'd2},  // R2 decimal refused
        {3'd4, 2'd0, 8'h00, 8'h01, 4'd2},
        {3'd1, 2'd3, 8'h00, 8'h00, 4'd4},  // R4 command address reads zero
        {3'd4, 2'd0, 8'h00, 8'h00, 4'd2}   // R2 pulse lasts one cycle
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic t_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_tick();
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic rd_word(input logic [1:0] a, input logic [15:0] exp, input string req);
        logic [7:0] lo;
        logic [7:0] hi;
        t_rd(a, lo);
        t_rd(a, hi);
        check({hi, lo} == exp, req, "two-byte read", int'({hi, lo}), int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(timer_out == 3'b000, "R1", "outputs after reset", int'(timer_out), 0);
        check(cmd_err == 1'b0, "R1", "error after reset", int'(cmd_err), 0);
        rd_word(2'd0, 16'h0000, "R1");

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            string rq;
            v = VEC[i];
            rq = $sformatf("R%0d", v[3:0]);
            case (v[24:22])
                3'd0: t_wr(v[21:20], v[19:12]);
                3'd1: begin
                    t_rd(v[21:20], b);
                    check(b == v[11:4], rq, $sformatf("vector %0d read", i), int'(b), int'(v[11:4]));
                end
                3'd2: t_tick();
                3'd3: check(timer_out == v[6:4], rq, $sformatf("vector %0d out", i),
                            int'(timer_out), int'(v[6:4]));
                default: check(cmd_err == v[4], rq, $sformatf("vector %0d cmd_err", i),
                               int'(cmd_err), int'(v[4]));
            endcase
        end

        // R2 refused byte keeps the write pointer where it was
        t_wr(2'd0, 8'h07);
        t_wr(2'd3, 8'h32);
        t_wr(2'd0, 8'h00);
        rd_word(2'd0, 16'h0007, "R2");

        // R10 accepted configuration resets the write pointer
        t_wr(2'd0, 8'h09);
        t_wr(2'd3, 8'h30);
        t_wr(2'd0, 8'h02);
        t_wr(2'd0, 8'h00);
        rd_word(2'd0, 16'h0002, "R10");

        // R3 zero value leaves the channel idle
        t_wr(2'd0, 8'h00);
        t_wr(2'd0, 8'h00);
        repeat (3) t_tick();
        check(timer_out[0] == 1'b0, "R3", "zero count output", int'(timer_out[0]), 0);
        rd_word(2'd0, 16'h0000, "R3");

        // R9 no counting without cnt_en
        t_wr(2'd0, 8'h04);
        t_wr(2'd0, 8'h01);
        repeat (10) @(negedge clk);
        rd_word(2'd0, 16'h0104, "R9");
        repeat (4) t_tick();
        rd_word(2'd0, 16'h0100, "R9");

        // R8 square wave on ch2 with N=5: high 3 enables, low 2
        t_wr(2'd3, 8'hB6);
        t_wr(2'd2, 8'h05);
        t_wr(2'd2, 8'h00);
        check(timer_out[2] == 1'b1, "R8", "square start", int'(timer_out[2]), 1);
        for (int k = 1; k <= 10; k++) begin
            t_tick();
            check(timer_out[2] == ((k % 5) < 3), "R8", $sformatf("square after %0d", k),
                  int'(timer_out[2]), int'((k % 5) < 3));
        end

        // R1 reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(timer_out == 3'b000, "R1", "outputs after mid-run reset", int'(timer_out), 0);
        rd_word(2'd2, 16'h0000, "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule